// File: doc/BRIEF.md
# Sixteen-Line Interrupt Expander

The block combines sixteen interrupt request inputs into a single active-high interrupt line for a host processor. Every request passes through a two-stage synchroniser. The synchronised level then sets a sticky pending bit. The host sees an interrupt while any pending bit is also enabled. Software finds the source by reading the pending register and scanning its bits. It then clears the bits it has serviced by writing ones to them.

Access is through a simple synchronous 16-bit register port. It has a byte address, write and read strobes, write data, and read data that is registered. Bit n of every register belongs to request input n. The enable mask has no direct write. Software can only turn bits on through a set address and turn bits off through a clear address, so two agents can change separate bits without a read-modify-write race. A separate address gives the live synchronised input levels, which is useful when polling level sources.

Top module: `irqx_expander`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the enable mask and the pending bits are all zero, irq_o is low and bus_rdata is zero.
- R2: A pending bit becomes set on the third rising edge after its request input goes high, counting the edge that samples the input as the first. This happens whether or not the source is enabled. The bit stays set after the request drops.
- R3: A write to offset 0x16 clears every pending bit whose write-data bit is 1. Pending bits written as 0 keep their value.
- R4: If a pending bit is cleared by a write in the same cycle that its synchronised request is high, the bit stays set.
- R5: A write to offset 0x1A sets each enable bit whose write-data bit is 1. The other enable bits are unchanged.
- R6: A write to offset 0x1C clears each enable bit whose write-data bit is 1. The other enable bits are unchanged.
- R7: A read of offset 0x1A or offset 0x1C returns the enable mask.
- R8: A read of offset 0x18 returns the synchronised request levels and changes no state. A read of offset 0x16 returns the pending bits and does not clear them.
- R9: irq_o is high exactly when the bitwise AND of the pending bits and the enable mask is nonzero. It follows a register update combinationally, with no added cycle.
- R10: A read of any other offset returns zero. A write to any other offset changes neither the mask nor the pending bits.
- R11: bus_rdata carries the addressed value in the cycle after the edge that samples bus_rd. In any cycle after an edge where bus_rd was low, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| req_i | input | 16 | Asynchronous interrupt request levels |
| irq_o | output | 1 | Combined active-high interrupt to the host |

## Verification
The assertions assume that the bus presents at most one decoded register per cycle. They also assume that the strobes and the address are stable across each rising edge. The bench meets both by changing every bus signal only on the falling edge and by decoding a single address per access. The assertions also assume that request inputs reach the pending logic only through the synchroniser. The bench therefore drives req_i freely, including pulses one cycle wide and levels held through a clear write, because the latency is counted from the synchronised level. Random traffic mixes reads and writes in the same cycle, which the model handles with the same register order.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    localparam int SRC_N  = 16;
    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] OFS_PEND = 8'h16;
    localparam logic [BUS_AW-1:0] OFS_LIVE = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_MSET = 8'h1A;
    localparam logic [BUS_AW-1:0] OFS_MCLR = 8'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_LIVE,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_e;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] stg;
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = stg[STAGES-1];
    end
endmodule

// File: rtl/irqx_regs.sv
module irqx_regs
    import irqx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_sel_e     sel,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] pend_q, mask_q;
    logic [W-1:0] pend_clr, mask_on, mask_off;

    always_comb begin
        pend_clr = '0;
        mask_on  = '0;
        mask_off = '0;
        if (wr) begin
            unique case (sel)
                SEL_PEND: pend_clr = wdata;
                SEL_MSET: mask_on  = wdata;
                SEL_MCLR: mask_off = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~pend_clr) | lvl;
            mask_q <= (mask_q | mask_on) & ~mask_off;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    // R2 R4
    pend_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(lvl)) == $past(lvl)));

    // R3
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(pend_clr)) == '0));

    // R5 R6 R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (sel == SEL_MSET || sel == SEL_MCLR)) |=> $stable(mask_q));
endmodule

// File: rtl/irqx_rdmux.sv
module irqx_rdmux
    import irqx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  reg_sel_e     sel,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] mask,
    output logic [W-1:0] rdata_o
);
    logic [W-1:0] rd_mux;

    always_comb begin
        unique case (sel)
            SEL_PEND:           rd_mux = pend;
            SEL_LIVE:           rd_mux = lvl;
            SEL_MSET, SEL_MCLR: rd_mux = mask;
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_o <= '0;
        else if (rd) rdata_o <= rd_mux;
        else         rdata_o <= '0;
    end

    // R11
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata_o == '0));

    // R10
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_NONE) |=> (rdata_o == '0));
endmodule

// File: rtl/irqx_expander.sv
module irqx_expander
    import irqx_pkg::*;
#(
    parameter int N_SRC  = irqx_pkg::SRC_N,
    parameter int ADDR_W = irqx_pkg::BUS_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    input  logic [N_SRC-1:0]  req_i,
    output logic              irq_o
);
    localparam int SYNC_STAGES = 2;

    reg_sel_e         sel;
    logic [N_SRC-1:0] lvl, pend, mask;

    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_PEND)) sel = SEL_PEND;
        else if (bus_addr == ADDR_W'(OFS_LIVE)) sel = SEL_LIVE;
        else if (bus_addr == ADDR_W'(OFS_MSET)) sel = SEL_MSET;
        else if (bus_addr == ADDR_W'(OFS_MCLR)) sel = SEL_MCLR;
        else                                    sel = SEL_NONE;
    end

    irqx_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(req_i), .q_o(lvl)
    );

    irqx_regs #(.W(N_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(bus_wr),
        .wdata(bus_wdata), .lvl(lvl), .pend_o(pend), .mask_o(mask)
    );

    irqx_rdmux #(.W(N_SRC)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(sel),
        .pend(pend), .lvl(lvl), .mask(mask), .rdata_o(bus_rdata)
    );

    assign irq_o = |(pend & mask);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend != '0) && (mask != '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !irq_o && (bus_rdata == '0));
endmodule

// File: tb/irqx_expander_test.sv
module irqx_expander_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0, req = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0, started = 0;

    always #4 clk = ~clk;

    irqx_expander uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_i(req), .irq_o(irq)
    );

    // behavioural reference
    logic [15:0] m_pend, m_mask, m_rdata, old_lvl, rnext, clrv, setv, offv;
    logic [15:0] dl[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_rdata = '0;
            dl = {16'h0, 16'h0};
            started = 1;
        end else begin
            old_lvl = dl[1];
            rnext = '0;
            if (bus_rd) begin
                case (bus_addr)
                    8'h16:        rnext = m_pend;
                    8'h18:        rnext = old_lvl;
                    8'h1A, 8'h1C: rnext = m_mask;
                    default:      rnext = '0;
                endcase
            end
            clrv = (bus_wr && bus_addr == 8'h16) ? bus_wdata : '0;
            setv = (bus_wr && bus_addr == 8'h1A) ? bus_wdata : '0;
            offv = (bus_wr && bus_addr == 8'h1C) ? bus_wdata : '0;
            m_pend  = (m_pend & ~clrv) | old_lvl;
            m_mask  = (m_mask | setv) & ~offv;
            m_rdata = rnext;
            dl.push_front(req);
            void'(dl.pop_back());
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && started && !done) begin
            check("R11 model rdata", bus_rdata, m_rdata);
            check("R9 model irq", {15'b0, irq}, {15'b0, |(m_pend & m_mask)});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); v = bus_rdata; bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        check("R1 irq after reset", {15'b0, irq}, 16'h0);
        check("R1 rdata after reset", bus_rdata, 16'h0);
        rd(8'h16, v); check("R1 pending after reset", v, 16'h0000);
        rd(8'h1A, v); check("R1 mask after reset", v, 16'h0000);
        // R5 R7
        wr(8'h1A, 16'h00A5);
        rd(8'h1A, v); check("R5 mask set", v, 16'h00A5);
        // R6 R7
        wr(8'h1C, 16'h0005);
        rd(8'h1C, v); check("R6 mask clear via clear addr", v, 16'h00A0);
        // R2 one-cycle pulse on masked sources
        @(negedge clk); req = 16'h0101;
        @(negedge clk); req = 16'h0000;
        idle(4);
        rd(8'h16, v); check("R2 pulse latched", v, 16'h0101);
        check("R9 masked pending no irq", {15'b0, irq}, 16'h0);
        // R9
        wr(8'h1A, 16'h0100);
        check("R9 irq on enable", {15'b0, irq}, 16'h0001);
        // R3
        wr(8'h16, 16'h0100);
        check("R3 irq after clear", {15'b0, irq}, 16'h0);
        rd(8'h16, v); check("R3 other bits kept", v, 16'h0001);
        // R8
        @(negedge clk); req = 16'h3C00;
        idle(3);
        rd(8'h18, v); check("R8 live levels", v, 16'h3C00);
        @(negedge clk); req = 16'h0000;
        idle(3);
        rd(8'h18, v); check("R8 live levels dropped", v, 16'h0000);
        rd(8'h16, v); check("R8 pending not cleared by read", v, 16'h3C01);
        rd(8'h16, v); check("R8 pending read twice", v, 16'h3C01);
        // R4
        @(negedge clk); req = 16'h0004;
        idle(3);
        wr(8'h16, 16'h3C05);
        rd(8'h16, v); check("R4 set wins over clear", v, 16'h0004);
        @(negedge clk); req = 16'h0000;
        idle(3);
        wr(8'h16, 16'h0004);
        rd(8'h16, v); check("R3 clear after source drops", v, 16'h0000);
        // R10
        wr(8'h20, 16'hFFFF);
        wr(8'h17, 16'hFFFF);
        rd(8'h20, v); check("R10 unmapped read", v, 16'h0000);
        rd(8'h1A, v); check("R10 mask untouched", v, 16'h01A0);
        rd(8'h16, v); check("R10 pending untouched", v, 16'h0000);
        // R11
        @(negedge clk); check("R11 idle rdata", bus_rdata, 16'h0000);
        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            case ($urandom_range(0, 5))
                0: bus_addr = 8'h16;
                1: bus_addr = 8'h18;
                2: bus_addr = 8'h1A;
                3: bus_addr = 8'h1C;
                4: bus_addr = 8'h1E;
                default: bus_addr = 8'(($urandom_range(0, 255)));
            endcase
            bus_wr    = ($urandom_range(0, 2) == 0);
            bus_rd    = ($urandom_range(0, 1) == 0);
            bus_wdata = 16'($urandom);
            if ($urandom_range(0, 3) == 0) req = 16'($urandom) & 16'($urandom);
        end
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0; req = '0;
        idle(4);
        done = 1;
        summary();
        $finish;
    end
endmodule